// File: doc/BRIEF.md
# Inter-Processor Doorbell Unit

This block lets any processor in a cluster ring software doorbells on one or more other processors. Every processor has its own register port. Through that port it reaches one shared trigger register and its own private pair of registers. The private pair holds the doorbells pending for that processor and the doorbells it has chosen to enable. One trigger write names a doorbell number and a bitmap of target processors. That doorbell then becomes pending in every processor the bitmap selects.

Each processor has one interrupt line. The line is high while any doorbell is both pending and enabled for that processor, and it feeds the lowest source of the interrupt controller. Software works in this order:

1. It reads the pending set in one access.
2. It writes zeros to retire the bits it has taken.
3. It serves each doorbell it retired.

All ports act in the same clock cycle. A trigger from one processor can therefore meet a clear from the target processor, and the trigger wins.

Top module: `ipi_doorbell`

## Requirements
- R1: After reset, every pending bit and every enable bit is zero, every interrupt line is low, and reads of the per-processor registers return zero.
- R2: A write on port p with `bus_percpu[p]`=0 and offset 0x04 carries the doorbell number n in data bits [7:0] and the target bitmap in data bits [8+NUM_CPU-1:8]. When n < NUM_BELL, the write sets pending bit n of every processor c whose target bit 8+c is 1. The change is visible from the clock edge that takes the write. Pending bits that were already set stay set.
- R3: A trigger write whose doorbell number in bits [7:0] is NUM_BELL or greater changes no pending bit.
- R4: A read on port c with `bus_percpu[c]`=1 and offset 0x08 returns processor c's pending bits in [NUM_BELL-1:0] and zeros above, with all pending bits visible together.
- R5: A write on port c with `bus_percpu[c]`=1 and offset 0x08 clears each pending bit of processor c whose data bit is 0. Each pending bit whose data bit is 1 is left unchanged.
- R6: If a trigger sets a pending bit in the same cycle that a clear write would clear that bit, the bit ends set.
- R7: A write on port c with `bus_percpu[c]`=1 and offset 0x0C loads data bits [NUM_BELL-1:0] into processor c's enable register. A read at that offset returns the register in the low bits and zeros above.
- R8: `bell_irq[c]` is high exactly when the bitwise AND of processor c's pending and enable bits is non-zero. It follows a write from the clock edge that takes the write and does not change before that edge.
- R9: Trigger writes from several ports in the same cycle all take effect.
- R10: Writes at other offsets, and writes with the wrong window select, change nothing. Such reads return zero. A per-processor write touches only the writing port's own processor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | NUM_CPU | Write strobe per processor port |
| bus_percpu | input | NUM_CPU | 1 selects the port's private window, 0 the shared window |
| bus_off | input | NUM_CPU*OFF_W | Byte offset per port |
| bus_wdata | input | NUM_CPU*(8+NUM_CPU) | Write data per port |
| bus_rdata | output | NUM_CPU*(8+NUM_CPU) | Read data per port, valid in the same cycle as the offset |
| bell_irq | output | NUM_CPU | Doorbell interrupt per processor |

## Verification
The one real collision is a trigger from another processor meeting a zero-write clear from the target processor on the same doorbell in the same cycle. A second port carries the trigger while the target's port issues the clear. The bench then checks that the doorbell survives and that the other cleared bits do not. A full sweep of doorbell numbers against target bitmaps follows, including numbers just beyond the active range. After each sweep step every processor's pending, enable and interrupt state is compared with values computed from the request.

// File: rtl/ipi_db_pkg.sv
package ipi_db_pkg;
    // Field layout of a trigger write
    localparam int TGT_LSB = 8;
    localparam int NUM_FW  = 8;
    // Register offsets
    localparam logic [7:0] OFF_TRIG  = 8'h04;
    localparam logic [7:0] OFF_CAUSE = 8'h08;
    localparam logic [7:0] OFF_MASK  = 8'h0C;
endpackage

// File: rtl/ipi_db_trig_dec.sv
module ipi_db_trig_dec
    import ipi_db_pkg::*;
#(
    parameter  int NUM_CPU  = 4,
    parameter  int NUM_BELL = 8,
    parameter  int OFF_W    = 8,
    localparam int DATA_W   = TGT_LSB + NUM_CPU,
    localparam int MAP_W    = NUM_CPU * NUM_BELL
) (
    input  logic              wr,
    input  logic              percpu,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [MAP_W-1:0]  set_map
);
    localparam int IDX_W = (NUM_BELL > 1) ? $clog2(NUM_BELL) : 1;
    localparam logic [NUM_FW-1:0] BELL_LIM = NUM_FW'(NUM_BELL);

    logic [NUM_FW-1:0]   num;
    logic                hit;
    logic [NUM_BELL-1:0] onehot;

    always_comb begin
        num    = wdata[NUM_FW-1:0];
        hit    = wr && !percpu && (off == OFF_W'(OFF_TRIG)) && (num < BELL_LIM);
        onehot = '0;
        onehot[num[IDX_W-1:0]] = 1'b1;
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_tgt
        assign set_map[c*NUM_BELL +: NUM_BELL] =
            (hit && wdata[TGT_LSB+c]) ? onehot : '0;
    end
endmodule

// File: rtl/ipi_db_cpu_bank.sv
module ipi_db_cpu_bank
    import ipi_db_pkg::*;
#(
    parameter int NUM_BELL = 8,
    parameter int OFF_W    = 8,
    parameter int DATA_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BELL-1:0] set_bits,
    input  logic                wr,
    input  logic                percpu,
    input  logic [OFF_W-1:0]    off,
    input  logic [NUM_BELL-1:0] wbits,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_BELL-1:0] cause_o,
    output logic [NUM_BELL-1:0] mask_o,
    output logic                irq_o
);
    typedef struct packed {
        logic [NUM_BELL-1:0] cause;
        logic [NUM_BELL-1:0] mask;
        logic                irq;
    } bank_t;

    bank_t st_d, st_q;
    logic  clr_hit, msk_hit;

    always_comb begin
        clr_hit = wr && percpu && (off == OFF_W'(OFF_CAUSE));
        msk_hit = wr && percpu && (off == OFF_W'(OFF_MASK));
        st_d = st_q;
        if (clr_hit) st_d.cause = st_q.cause & wbits;
        if (msk_hit) st_d.mask  = wbits;
        // a trigger in the same cycle wins over the clear
        st_d.cause = st_d.cause | set_bits;
        st_d.irq   = |(st_d.cause & st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (percpu) begin
            if (off == OFF_W'(OFF_CAUSE))     rdata[NUM_BELL-1:0] = st_q.cause;
            else if (off == OFF_W'(OFF_MASK)) rdata[NUM_BELL-1:0] = st_q.mask;
        end
    end

    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;
    assign irq_o   = st_q.irq;
endmodule

// File: rtl/ipi_doorbell.sv
module ipi_doorbell
    import ipi_db_pkg::*;
#(
    parameter  int NUM_CPU  = 4,
    parameter  int NUM_BELL = 8,
    parameter  int OFF_W    = 8,
    localparam int DATA_W   = TGT_LSB + NUM_CPU
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CPU-1:0]        bus_wr,
    input  logic [NUM_CPU-1:0]        bus_percpu,
    input  logic [NUM_CPU*OFF_W-1:0]  bus_off,
    input  logic [NUM_CPU*DATA_W-1:0] bus_wdata,
    output logic [NUM_CPU*DATA_W-1:0] bus_rdata,
    output logic [NUM_CPU-1:0]        bell_irq
);
    localparam int MAP_W = NUM_CPU * NUM_BELL;

    logic [MAP_W-1:0] port_map [NUM_CPU];
    logic [MAP_W-1:0] set_all;
    logic [MAP_W-1:0] cause_all;
    logic [MAP_W-1:0] mask_all;

    for (genvar p = 0; p < NUM_CPU; p++) begin : g_port
        ipi_db_trig_dec #(
            .NUM_CPU (NUM_CPU),
            .NUM_BELL(NUM_BELL),
            .OFF_W   (OFF_W)
        ) u_dec (
            .wr     (bus_wr[p]),
            .percpu (bus_percpu[p]),
            .off    (bus_off[p*OFF_W +: OFF_W]),
            .wdata  (bus_wdata[p*DATA_W +: DATA_W]),
            .set_map(port_map[p])
        );
    end

    always_comb begin
        set_all = '0;
        for (int p = 0; p < NUM_CPU; p++) set_all = set_all | port_map[p];
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        ipi_db_cpu_bank #(
            .NUM_BELL(NUM_BELL),
            .OFF_W   (OFF_W),
            .DATA_W  (DATA_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_bits(set_all[c*NUM_BELL +: NUM_BELL]),
            .wr      (bus_wr[c]),
            .percpu  (bus_percpu[c]),
            .off     (bus_off[c*OFF_W +: OFF_W]),
            .wbits   (bus_wdata[c*DATA_W +: NUM_BELL]),
            .rdata   (bus_rdata[c*DATA_W +: DATA_W]),
            .cause_o (cause_all[c*NUM_BELL +: NUM_BELL]),
            .mask_o  (mask_all[c*NUM_BELL +: NUM_BELL]),
            .irq_o   (bell_irq[c])
        );
    end
endmodule

// File: rtl/ipi_doorbell_chk.sv
module ipi_doorbell_chk
    import ipi_db_pkg::*;
#(
    parameter  int NUM_CPU  = 4,
    parameter  int NUM_BELL = 8,
    parameter  int OFF_W    = 8,
    localparam int DATA_W   = TGT_LSB + NUM_CPU,
    localparam int MAP_W    = NUM_CPU * NUM_BELL
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_CPU-1:0]        bus_wr,
    input logic [NUM_CPU-1:0]        bus_percpu,
    input logic [NUM_CPU*OFF_W-1:0]  bus_off,
    input logic [NUM_CPU*DATA_W-1:0] bus_wdata,
    input logic [NUM_CPU*DATA_W-1:0] bus_rdata,
    input logic [NUM_CPU-1:0]        bell_irq,
    input logic [MAP_W-1:0]          cause_all,
    input logic [MAP_W-1:0]          mask_all
);
    logic [NUM_CPU-1:0] tgt_ok, clr_wr, msk_wr, rd_other;

    always_comb begin
        tgt_ok = '0;
        for (int p = 0; p < NUM_CPU; p++) begin
            if (bus_wr[p] && !bus_percpu[p] &&
                bus_off[p*OFF_W +: OFF_W] == OFF_W'(OFF_TRIG) &&
                bus_wdata[p*DATA_W +: NUM_FW] < NUM_FW'(NUM_BELL))
                tgt_ok = tgt_ok | bus_wdata[p*DATA_W+TGT_LSB +: NUM_CPU];
        end
        for (int c = 0; c < NUM_CPU; c++) begin
            clr_wr[c] = bus_wr[c] && bus_percpu[c] &&
                        bus_off[c*OFF_W +: OFF_W] == OFF_W'(OFF_CAUSE);
            msk_wr[c] = bus_wr[c] && bus_percpu[c] &&
                        bus_off[c*OFF_W +: OFF_W] == OFF_W'(OFF_MASK);
            rd_other[c] = !bus_percpu[c] ||
                          (bus_off[c*OFF_W +: OFF_W] != OFF_W'(OFF_CAUSE) &&
                           bus_off[c*OFF_W +: OFF_W] != OFF_W'(OFF_MASK));
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        AST_NEW_BIT_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
            (cause_all[c*NUM_BELL +: NUM_BELL] & ~$past(cause_all[c*NUM_BELL +: NUM_BELL])) != '0
            |-> $past(tgt_ok[c])); // R2
        AST_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (~cause_all[c*NUM_BELL +: NUM_BELL] & $past(cause_all[c*NUM_BELL +: NUM_BELL])) != '0
            |-> $past(clr_wr[c])); // R5
        AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(msk_wr[c]) |-> $stable(mask_all[c*NUM_BELL +: NUM_BELL])); // R7
        AST_IRQ_RISE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(bell_irq[c]) |-> $past(tgt_ok[c] || msk_wr[c])); // R8
        AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rdata[c*DATA_W+NUM_BELL +: DATA_W-NUM_BELL] == '0); // R4
        AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            rd_other[c] |-> bus_rdata[c*DATA_W +: DATA_W] == '0); // R10
    end
endmodule

bind ipi_doorbell ipi_doorbell_chk #(
    .NUM_CPU (NUM_CPU),
    .NUM_BELL(NUM_BELL),
    .OFF_W   (OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_percpu(bus_percpu),
    .bus_off   (bus_off),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bell_irq  (bell_irq),
    .cause_all (cause_all),
    .mask_all  (mask_all)
);

// File: tb/ipi_doorbell_tb_top.sv
`timescale 1ns/1ps
module ipi_doorbell_tb_top;
    localparam int NC = 4;
    localparam int NB = 8;
    localparam int OW = 8;
    localparam int DW = 8 + NC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic            d_wr  [NC];
    logic            d_pc  [NC];
    logic [OW-1:0]   d_off [NC];
    logic [DW-1:0]   d_dat [NC];

    logic [NC-1:0]    bus_wr, bus_percpu, bell_irq;
    logic [NC*OW-1:0] bus_off;
    logic [NC*DW-1:0] bus_wdata, bus_rdata;

    always_comb begin
        for (int p = 0; p < NC; p++) begin
            bus_wr[p]                 = d_wr[p];
            bus_percpu[p]             = d_pc[p];
            bus_off[p*OW +: OW]       = d_off[p];
            bus_wdata[p*DW +: DW]     = d_dat[p];
        end
    end

    ipi_doorbell #(.NUM_CPU(NC), .NUM_BELL(NB), .OFF_W(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_percpu(bus_percpu),
        .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bell_irq(bell_irq)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [NB-1:0] exp_c [NC];
    logic [NB-1:0] exp_m [NC];

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
        end
    endtask

    task automatic clr_bus();
        for (int p = 0; p < NC; p++) begin
            d_wr[p] = 1'b0; d_pc[p] = 1'b0; d_off[p] = '0; d_dat[p] = '0;
        end
    endtask

    task automatic put(int p, bit pc, logic [7:0] off, logic [DW-1:0] dat);
        d_wr[p] = 1'b1; d_pc[p] = pc; d_off[p] = off; d_dat[p] = dat;
    endtask

    // expected next state from the driven requests, then one clock
    task automatic step();
        logic [NB-1:0] nc [NC];
        logic [NB-1:0] nm [NC];
        for (int c = 0; c < NC; c++) begin
            nc[c] = exp_c[c]; nm[c] = exp_m[c];
            if (d_wr[c] && d_pc[c] && d_off[c] == 8'h08) nc[c] = exp_c[c] & d_dat[c][NB-1:0];
            if (d_wr[c] && d_pc[c] && d_off[c] == 8'h0C) nm[c] = d_dat[c][NB-1:0];
        end
        for (int p = 0; p < NC; p++) begin
            if (d_wr[p] && !d_pc[p] && d_off[p] == 8'h04 && d_dat[p][7:0] < NB)
                for (int c = 0; c < NC; c++)
                    if (d_dat[p][8+c]) nc[c] = nc[c] | (NB'(1) << d_dat[p][2:0]);
        end
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            exp_c[c] = nc[c]; exp_m[c] = nm[c];
        end
        clr_bus();
    endtask

    task automatic check_cpu(string tag);
        for (int c = 0; c < NC; c++) begin
            d_pc[c] = 1'b1; d_off[c] = 8'h08; #1;
            check(tag, $sformatf("cause cpu%0d", c), 32'(bus_rdata[c*DW +: DW]), 32'(exp_c[c]));
            d_off[c] = 8'h0C; #1;
            check(tag, $sformatf("mask cpu%0d", c), 32'(bus_rdata[c*DW +: DW]), 32'(exp_m[c]));
            check(tag, $sformatf("irq cpu%0d", c), 32'(bell_irq[c]), 32'(|(exp_c[c] & exp_m[c])));
            d_pc[c] = 1'b0; d_off[c] = '0;
        end
    endtask

    task automatic clear_all();
        for (int c = 0; c < NC; c++) put(c, 1'b1, 8'h08, '0);
        step();
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog got=running exp=finished");
            finish_up();
        end
    end

    initial begin
        logic [7:0] num;
        clr_bus();
        for (int c = 0; c < NC; c++) begin exp_c[c] = '0; exp_m[c] = '0; end
        repeat (3) @(negedge clk);
        check_cpu("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_cpu("R1");

        // R7: every processor loads its own enable pattern in the same cycle
        for (int c = 0; c < NC; c++) put(c, 1'b1, 8'h0C, DW'(8'h5A >> c) | DW'(1 << c));
        step();
        check_cpu("R7");

        // R2/R3/R4/R8: sweep doorbell number against every target bitmap
        for (int k = 0; k < 14; k++) begin
            num = (k < 12) ? 8'(k) : ((k == 12) ? 8'd128 : 8'd255);
            for (int t = 0; t < 16; t++) begin
                put(k % NC, 1'b0, 8'h04, {4'(t), num});
                step();
                check_cpu(num < NB ? "R2" : "R3");
            end
            clear_all();
            check_cpu("R5");
        end

        // R5: partial zero-write clear, upper data bits set
        for (int b = 0; b < NB; b++) begin
            put(b % NC, 1'b0, 8'h04, {4'hF, 8'(b)});
            step();
        end
        check_cpu("R4");
        for (int c = 0; c < NC; c++) put(c, 1'b1, 8'h08, {4'hF, 8'hF0 ^ 8'(c * 8'h11)});
        step();
        check_cpu("R5");
        clear_all();

        // R6: trigger from port 0 meets clear from port 1 on the same bell
        put(0, 1'b0, 8'h04, {4'b0010, 8'd5}); step();
        put(0, 1'b0, 8'h04, {4'b0010, 8'd2}); step();
        put(0, 1'b0, 8'h04, {4'b0010, 8'd2});
        put(1, 1'b1, 8'h08, '0);
        step();
        check("R6", "cause cpu1 after collision", 32'(exp_c[1]), 32'h04);
        check_cpu("R6");
        clear_all();

        // R9: all ports trigger in one cycle, two of them on the same bell
        for (int p = 0; p < NC; p++)
            put(p, 1'b0, 8'h04, {4'(1 << ((p + 1) % NC)) | 4'b0001, 8'(p == 3 ? 0 : p)});
        step();
        check("R9", "cause cpu0", 32'(exp_c[0]), 32'h07);
        check_cpu("R9");
        clear_all();

        // R10: writes at wrong offsets or window leave state untouched
        put(0, 1'b1, 8'h04, {4'hF, 8'd1});
        put(1, 1'b0, 8'h08, '0);
        put(2, 1'b1, 8'h10, '1);
        put(3, 1'b0, 8'h0C, '1);
        step();
        check_cpu("R10");
        put(2, 1'b1, 8'h0C, DW'(8'hFF));
        step();
        check_cpu("R10");
        d_pc[1] = 1'b1; d_off[1] = 8'h10; #1;
        check("R10", "read unmapped", 32'(bus_rdata[1*DW +: DW]), 32'h0);
        d_pc[1] = 1'b0; d_off[1] = 8'h08; #1;
        check("R10", "read shared window", 32'(bus_rdata[1*DW +: DW]), 32'h0);
        clr_bus();

        // R8: interrupt timing and enable gating
        put(3, 1'b1, 8'h0C, DW'(8'h01)); step();
        put(0, 1'b0, 8'h04, {4'b1000, 8'd1}); #1;
        check("R8", "irq before edge", 32'(bell_irq[3]), 32'h0);
        step();
        check("R8", "masked bell irq", 32'(bell_irq[3]), 32'h0);
        put(0, 1'b0, 8'h04, {4'b1000, 8'd0}); #1;
        check("R8", "irq before edge", 32'(bell_irq[3]), 32'h0);
        step();
        check("R8", "enabled bell irq", 32'(bell_irq[3]), 32'h1);
        put(3, 1'b1, 8'h0C, '0); step();
        check("R8", "irq after disable", 32'(bell_irq[3]), 32'h0);
        check_cpu("R8");

        done = 1'b1;
        finish_up();
    end
endmodule